// File: doc/BRIEF.md
# ADC SPI Register Interface

This block is the device side of the serial control and data port of a single-channel 24-bit converter. A host talks to it in SPI mode 0 over SCLK, chip select, MOSI and MISO. Each framed transfer starts with a command byte that selects a register and says whether it is read or written. A small set of byte-wide configuration registers can be read and written. The conversion-result register returns the latest sample as three bytes.

New samples arrive on a parallel port. A data-ready output pulses according to the conversion mode held in a register. A streaming mode lets the host pull the latest result in every frame without sending a command. A two-step write pattern to the sync register restores every register to its default. The serial inputs are oversampled by the system clock `clk`, so all state lives in one clock domain.

Top module: `adc_spi_regif`

## Requirements
- R1: The first byte of a frame is a command: bit 6 = 1 means read, bit 6 = 0 means write, and bits 5:0 are the register address. The scratch register at 0x0A stores and returns all 8 bits.
- R2: A write commits only when the full data byte after the command has been received. Raising chip select earlier leaves every register unchanged.
- R3: A register read returns one byte, MSB first, in the byte after the command. Addresses other than 0x0A, 0x14, 0x18, 0x1D and 0x2C read 0x00 and ignore writes.
- R4: A read of 0x2C returns the 24-bit latest sample as three bytes, MSB first. The sample is captured when the command byte completes, so a sample that arrives later in the same frame does not change the bytes returned.
- R5: Writing 1 to bit 0 of register 0x14 enables streaming. In that mode, every frame shifts out the 3 bytes of the latest sample from its first SCLK cycle, and the MOSI bytes of the frame are not decoded as commands or writes.
- R6: In streaming mode, a frame whose first MOSI byte is 0x6C (read of 0x2C) still returns the sample bytes, and then clears bit 0 of 0x14, so later frames are decoded normally.
- R7: Writing 0x1D with bits 1:0 = 11, and then writing 0x1D again with bits 1:0 = 10, returns every register to 0x00 and turns streaming off. Writes to other addresses between the two do not break the pattern. Any other value written to 0x1D in between does break it.
- R8: Bits 2:0 of 0x18 hold the conversion mode (0 continuous, 1 one-shot, 2 single, 3 periodic, 4 standby). In mode 0, `drdy` is high for exactly the clock cycle after each cycle in which `sample_valid` is high.
- R9: In mode 1, only the first sample after a write to 0x18 raises `drdy`. Later samples raise nothing until 0x18 is written again.
- R10: In modes 2 to 7, `drdy` stays low.
- R11: MOSI is taken on rising SCLK edges. MISO changes only after falling SCLK edges, or when chip select falls, and never while SCLK is high.
- R12: After `rst`, every register reads 0x00, streaming is off, the mode is continuous, and `miso` and `drdy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sample_valid | input | 1 | One-cycle strobe that marks a new sample |
| sample_data | input | 24 | New conversion result |
| drdy | output | 1 | One-cycle data-ready pulse |

## Verification
The register path is driven with walking-one and alternating data patterns to the scratch register, which separates stuck, swapped or dropped data bits. All 64 addresses are then swept after writes to the unused ones, which separates correct address decode from aliasing. Result reads use samples with all zeros, all ones, and asymmetric MSB/LSB patterns, so byte order and bit order show up as distinct mismatches. A sample is also pushed in the middle of a frame to test when the data is captured. Data-ready is driven through every mode value, with repeated samples, to separate per-sample, one-time and silent behaviour. Frames that are aborted, streamed, or send a sync-register write pattern show whether writes are gated and reset is triggered only by the exact sequence.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int SMP_W      = 24;
    localparam int DATA_BYTES = SMP_W / BYTE_W;
    localparam int SEL_W      = $clog2(DATA_BYTES);
    localparam int BCNT_W     = $clog2(BYTE_W);
    localparam int RD_BIT     = 6;
    localparam int MODE_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 6'h0A;
    localparam logic [ADDR_W-1:0] ADDR_IFMT    = 6'h14;
    localparam logic [ADDR_W-1:0] ADDR_CONV    = 6'h18;
    localparam logic [ADDR_W-1:0] ADDR_SYNC    = 6'h1D;
    localparam logic [ADDR_W-1:0] ADDR_DATA    = 6'h2C;

    localparam logic [MODE_W-1:0] MODE_CONT    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'd1;

    localparam logic [1:0] SYNC_ARM  = 2'b11;
    localparam logic [1:0] SYNC_FIRE = 2'b10;

    localparam logic [BYTE_W-1:0] REG_DEFAULT = 8'h00;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WDATA,
        PH_RD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Byte number sel of a sample, counted from the most significant byte.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [SMP_W-1:0] s,
                                                    input logic [SEL_W-1:0] sel);
        logic [SMP_W-1:0] t;
        t = s << (BYTE_W * int'(sel));
        return t[SMP_W-1 -: BYTE_W];
    endfunction

    // Command byte that reads the result register.
    function automatic logic [BYTE_W-1:0] data_read_cmd();
        logic [BYTE_W-1:0] c;
        c = '0;
        c[RD_BIT] = 1'b1;
        c[ADDR_W-1:0] = ADDR_DATA;
        return c;
    endfunction

endpackage

// File: rtl/adc_spi_phy.sv
module adc_spi_phy
    import adc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] preload,
    input  logic [BYTE_W-1:0] next_tx,
    output logic              cs_act,
    output logic              cs_start,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    logic              sclk_s, sclk_p, cs_s, cs_p, mosi_s;
    logic [BCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              load_pend;
    logic              rise, fall;

    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

    // Input sampling and edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= 1'b0;
            sclk_p <= 1'b0;
            cs_s   <= 1'b0;
            cs_p   <= 1'b0;
            mosi_s <= 1'b0;
        end else begin
            sclk_s <= sclk;
            sclk_p <= sclk_s;
            cs_s   <= ~cs_n;
            cs_p   <= cs_s;
            mosi_s <= mosi;
        end
    end

    assign cs_act    = cs_s;
    assign cs_start  = cs_s & ~cs_p;
    assign rise      = cs_s & sclk_s & ~sclk_p;
    assign fall      = cs_s & ~sclk_s & sclk_p;
    assign byte_done = rise && (bit_cnt == LAST_BIT);
    assign rx_byte   = {rx_sh, mosi_s};
    assign miso      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
        end else if (!cs_s) begin
            bit_cnt   <= '0;
            load_pend <= 1'b0;
        end else begin
            if (cs_start) begin
                tx_sh <= preload;
            end
            if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + BCNT_W'(1);
                if (bit_cnt == LAST_BIT) begin
                    load_pend <= 1'b1;
                end
            end
            if (fall) begin
                if (load_pend) begin
                    tx_sh     <= next_tx;
                    load_pend <= 1'b0;
                end else begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              stream_en,
    input  logic              sample_valid,
    input  logic [SMP_W-1:0]  sample_in,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] preload,
    output logic [BYTE_W-1:0] next_tx,
    output wr_req_t           wr_req,
    output logic              stream_exit
);

    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(DATA_BYTES - 1);

    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic              is_data;
    logic              strm;
    logic [SMP_W-1:0]  snap;
    logic [SMP_W-1:0]  latest;

    assign rd_addr = addr;
    assign preload = stream_en ? latest[SMP_W-1 -: BYTE_W] : '0;

    always_comb begin
        next_tx = '0;
        if (phase == PH_RD) begin
            next_tx = is_data ? pick_byte(snap, sel) : reg_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latest <= '0;
        end else if (sample_valid) begin
            latest <= sample_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_CMD;
            addr        <= '0;
            sel         <= '0;
            is_data     <= 1'b0;
            strm        <= 1'b0;
            snap        <= '0;
            wr_req      <= '0;
            stream_exit <= 1'b0;
        end else begin
            wr_req.en   <= 1'b0;
            stream_exit <= 1'b0;
            if (!cs_act) begin
                phase <= PH_CMD;
                strm  <= 1'b0;
            end else if (cs_start) begin
                if (stream_en) begin
                    phase   <= PH_RD;
                    is_data <= 1'b1;
                    sel     <= '0;
                    snap    <= latest;
                    strm    <= 1'b1;
                end else begin
                    phase <= PH_CMD;
                end
            end else if (byte_done) begin
                case (phase)
                    PH_CMD: begin
                        addr <= rx_byte[ADDR_W-1:0];
                        if (rx_byte[RD_BIT]) begin
                            phase   <= PH_RD;
                            is_data <= (rx_byte[ADDR_W-1:0] == ADDR_DATA);
                            sel     <= '0;
                            snap    <= latest;
                        end else begin
                            phase <= PH_WDATA;
                        end
                    end
                    PH_WDATA: begin
                        wr_req.en   <= 1'b1;
                        wr_req.addr <= addr;
                        wr_req.data <= rx_byte;
                        phase       <= PH_DONE;
                    end
                    PH_RD: begin
                        if (strm && (sel == '0) && (rx_byte == data_read_cmd())) begin
                            stream_exit <= 1'b1;
                        end
                        if (is_data && (sel != LAST_SEL)) begin
                            sel <= sel + SEL_W'(1);
                        end else begin
                            phase <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_spi_regs.sv
module adc_spi_regs
    import adc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              stream_exit,
    output logic [BYTE_W-1:0] rd_data,
    output logic              stream_en,
    output logic [MODE_W-1:0] conv_mode,
    output logic              conv_wr,
    output logic              soft_rst
);

    logic [BYTE_W-1:0] scratch_q, ifmt_q, conv_q, sync_q;
    logic              armed;

    assign soft_rst  = wr_req.en && (wr_req.addr == ADDR_SYNC) &&
                       (wr_req.data[1:0] == SYNC_FIRE) && armed;
    assign conv_wr   = wr_req.en && (wr_req.addr == ADDR_CONV);
    assign stream_en = ifmt_q[0];
    assign conv_mode = conv_q[MODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            scratch_q <= REG_DEFAULT;
            ifmt_q    <= REG_DEFAULT;
            conv_q    <= REG_DEFAULT;
            sync_q    <= REG_DEFAULT;
            armed     <= 1'b0;
        end else begin
            if (stream_exit) begin
                ifmt_q[0] <= 1'b0;
            end
            if (wr_req.en) begin
                case (wr_req.addr)
                    ADDR_SCRATCH: scratch_q <= wr_req.data;
                    ADDR_IFMT:    ifmt_q    <= wr_req.data;
                    ADDR_CONV:    conv_q    <= wr_req.data;
                    ADDR_SYNC: begin
                        sync_q <= wr_req.data;
                        armed  <= (wr_req.data[1:0] == SYNC_ARM);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_SCRATCH: rd_data = scratch_q;
            ADDR_IFMT:    rd_data = ifmt_q;
            ADDR_CONV:    rd_data = conv_q;
            ADDR_SYNC:    rd_data = sync_q;
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_drdy_gen.sv
module adc_drdy_gen
    import adc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              conv_wr,
    input  logic              sample_valid,
    input  logic [MODE_W-1:0] conv_mode,
    output logic              drdy
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            drdy  <= 1'b0;
            armed <= 1'b0;
        end else begin
            drdy <= 1'b0;
            if (sample_valid) begin
                if (conv_mode == MODE_CONT) begin
                    drdy <= 1'b1;
                end else if (conv_mode == MODE_ONESHOT && armed) begin
                    drdy  <= 1'b1;
                    armed <= 1'b0;
                end
            end
            if (conv_wr) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_spi_regif.sv
module adc_spi_regif
    import adc_spi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    input  logic             sample_valid,
    input  logic [SMP_W-1:0] sample_data,
    output logic             drdy
);

    logic              cs_act, cs_start, byte_done;
    logic [BYTE_W-1:0] rx_byte, preload, next_tx, reg_rdata;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr_req;
    logic              stream_exit, stream_en, conv_wr, soft_rst;
    logic [MODE_W-1:0] conv_mode;

    adc_spi_phy u_phy (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .preload   (preload),
        .next_tx   (next_tx),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    adc_spi_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .cs_act       (cs_act),
        .cs_start     (cs_start),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .stream_en    (stream_en),
        .sample_valid (sample_valid),
        .sample_in    (sample_data),
        .reg_rdata    (reg_rdata),
        .rd_addr      (rd_addr),
        .preload      (preload),
        .next_tx      (next_tx),
        .wr_req       (wr_req),
        .stream_exit  (stream_exit)
    );

    adc_spi_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .rd_addr     (rd_addr),
        .stream_exit (stream_exit),
        .rd_data     (reg_rdata),
        .stream_en   (stream_en),
        .conv_mode   (conv_mode),
        .conv_wr     (conv_wr),
        .soft_rst    (soft_rst)
    );

    adc_drdy_gen u_drdy (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .conv_wr      (conv_wr),
        .sample_valid (sample_valid),
        .conv_mode    (conv_mode),
        .drdy         (drdy)
    );

endmodule

// File: rtl/adc_spi_regif_chk.sv
module adc_spi_regif_chk
    import adc_spi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              sample_valid,
    input logic              drdy,
    input logic              miso,
    input logic              byte_done,
    input logic              wr_en,
    input logic              soft_rst,
    input logic              stream_exit,
    input logic              stream_en,
    input logic [MODE_W-1:0] conv_mode
);

    logic sc1, sc2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc1 <= 1'b0;
            sc2 <= 1'b0;
        end else begin
            sc1 <= sclk;
            sc2 <= sc1;
        end
    end

    // R11
    miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sc1 && sc2) |-> $stable(miso));

    // R8
    drdy_src_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |-> $past(sample_valid));

    // R10
    drdy_mode_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |-> ($past(conv_mode) <= MODE_ONESHOT));

    // R2
    wr_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(byte_done));

    // R7
    soft_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (conv_mode == MODE_CONT && !stream_en));

    // R6
    strm_exit_chk: assert property (@(posedge clk) disable iff (rst)
        stream_exit |=> !stream_en);

endmodule

bind adc_spi_regif adc_spi_regif_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sclk         (sclk),
    .sample_valid (sample_valid),
    .drdy         (drdy),
    .miso         (miso),
    .byte_done    (byte_done),
    .wr_en        (wr_req.en),
    .soft_rst     (soft_rst),
    .stream_exit  (stream_exit),
    .stream_en    (stream_en),
    .conv_mode    (conv_mode)
);

// File: tb/adc_spi_regif_tb.sv
module adc_spi_regif_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        sample_valid = 1'b0;
    logic [23:0] sample_data = '0;
    logic        drdy;

    int n_chk = 0;
    int n_err = 0;
    int r11_bad = 0;

    logic [7:0]  m_scratch = 8'h00, m_ifmt = 8'h00, m_conv = 8'h00, m_sync = 8'h00;
    logic [23:0] m_latest = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_spi_regif u_dut (
        .clk          (clk),
        .rst          (rst),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .mosi         (mosi),
        .miso         (miso),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .drdy         (drdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        logic m_at_rise;
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            m_at_rise = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (miso !== m_at_rise) r11_bad++;
            sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] rx;
        cs_low();
        spi_byte({2'b00, a}, rx);
        spi_byte(d, rx);
        cs_high();
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [7:0] d);
        logic [7:0] rx;
        cs_low();
        spi_byte({2'b01, a}, rx);
        spi_byte(8'h00, d);
        cs_high();
    endtask

    task automatic data_read(output logic [23:0] d);
        logic [7:0] rx;
        cs_low();
        spi_byte(8'h6C, rx);
        spi_byte(8'h00, d[23:16]);
        spi_byte(8'h00, d[15:8]);
        spi_byte(8'h00, d[7:0]);
        cs_high();
    endtask

    task automatic stream_read(input logic [7:0] first, output logic [23:0] d);
        cs_low();
        spi_byte(first, d[23:16]);
        spi_byte(8'h00, d[15:8]);
        spi_byte(8'h00, d[7:0]);
        cs_high();
    endtask

    task automatic push(input logic [23:0] s, input logic exp_pulse, input string req);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_data  = s;
        @(negedge clk);
        sample_valid = 1'b0;
        m_latest     = s;
        chk(req, {31'd0, drdy}, {31'd0, exp_pulse});
        @(negedge clk);
        chk(req, {31'd0, drdy}, 32'd0);
    endtask

    function automatic logic [7:0] model_read(input logic [5:0] a);
        case (a)
            6'h0A:   return m_scratch;
            6'h14:   return m_ifmt;
            6'h18:   return m_conv;
            6'h1D:   return m_sync;
            6'h2C:   return m_latest[23:16];
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0]  rb;
        logic [23:0] rd;
        logic [7:0]  pats [10];

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 miso", {31'd0, miso}, 32'd0);
        chk("R12 drdy", {31'd0, drdy}, 32'd0);
        reg_read(6'h0A, rb); chk("R12 scratch", {24'd0, rb}, 32'h00);
        reg_read(6'h14, rb); chk("R12 ifmt", {24'd0, rb}, 32'h00);
        reg_read(6'h18, rb); chk("R12 conv", {24'd0, rb}, 32'h00);
        reg_read(6'h1D, rb); chk("R12 sync", {24'd0, rb}, 32'h00);

        // R1: scratch sweep with walking ones and alternating patterns
        for (int i = 0; i < 8; i++) pats[i] = 8'h01 << i;
        pats[8] = 8'hA5;
        pats[9] = 8'h5A;
        for (int i = 0; i < 10; i++) begin
            reg_write(6'h0A, pats[i]);
            m_scratch = pats[i];
            reg_read(6'h0A, rb);
            chk("R1 scratch", {24'd0, rb}, {24'd0, pats[i]});
        end

        // R3: set implemented registers, write all unused ones, sweep reads
        reg_write(6'h14, 8'hFE); m_ifmt = 8'hFE;
        reg_write(6'h18, 8'h05); m_conv = 8'h05;
        reg_write(6'h1D, 8'h01); m_sync = 8'h01;
        for (int a = 0; a < 64; a++) begin
            if (a != 'h0A && a != 'h14 && a != 'h18 && a != 'h1D)
                reg_write(6'(a), 8'(a) ^ 8'hC3);
        end
        for (int a = 0; a < 64; a++) begin
            reg_read(6'(a), rb);
            chk("R3 addr sweep", {18'd0, 6'(a), rb}, {18'd0, 6'(a), model_read(6'(a))});
        end

        // R10: modes 5, 2, 3, 4 give no pulses
        push(24'h111111, 1'b0, "R10 mode5");
        for (int m = 2; m <= 4; m++) begin
            reg_write(6'h18, 8'(m)); m_conv = 8'(m);
            push(24'h222222, 1'b0, "R10 mode2to4");
        end

        // R8: continuous mode pulses per sample
        reg_write(6'h18, 8'h00); m_conv = 8'h00;
        for (int k = 0; k < 3; k++) push(24'(k * 24'h010203), 1'b1, "R8 continuous");

        // R9: one-shot
        reg_write(6'h18, 8'h01); m_conv = 8'h01;
        push(24'h0A0B0C, 1'b1, "R9 oneshot first");
        push(24'h0D0E0F, 1'b0, "R9 oneshot second");
        push(24'h101112, 1'b0, "R9 oneshot third");
        reg_write(6'h18, 8'h01);
        push(24'h131415, 1'b1, "R9 oneshot rearm");

        // R4: result reads with distinct bit patterns
        reg_write(6'h18, 8'h00); m_conv = 8'h00;
        begin
            logic [23:0] smp [5];
            smp[0] = 24'h000000; smp[1] = 24'hFFFFFF; smp[2] = 24'h123456;
            smp[3] = 24'h800001; smp[4] = 24'hA5C3E1;
            for (int k = 0; k < 5; k++) begin
                push(smp[k], 1'b1, "R8 continuous");
                data_read(rd);
                chk("R4 data read", {8'd0, rd}, {8'd0, smp[k]});
            end
        end
        // R4: sample arriving after the command byte is not seen
        push(24'h3C5A78, 1'b1, "R8 continuous");
        cs_low();
        spi_byte(8'h6C, rb);
        push(24'h999999, 1'b1, "R8 continuous");
        spi_byte(8'h00, rd[23:16]);
        spi_byte(8'h00, rd[15:8]);
        spi_byte(8'h00, rd[7:0]);
        cs_high();
        chk("R4 capture at command", {8'd0, rd}, 32'h003C5A78);

        // R2: aborted writes commit nothing
        reg_write(6'h0A, 8'h33); m_scratch = 8'h33;
        cs_low();
        spi_byte(8'h0A, rb);
        spi_bits(8'h77, 5, rb);
        cs_high();
        reg_read(6'h0A, rb); chk("R2 abort mid data", {24'd0, rb}, 32'h33);
        cs_low();
        spi_byte(8'h0A, rb);
        cs_high();
        reg_read(6'h0A, rb); chk("R2 abort after command", {24'd0, rb}, 32'h33);

        // R7: soft reset sequencing
        reg_write(6'h0A, 8'h44); m_scratch = 8'h44;
        reg_write(6'h1D, 8'h03);
        reg_write(6'h1D, 8'h01);
        reg_write(6'h1D, 8'h02); m_sync = 8'h02;
        reg_read(6'h0A, rb); chk("R7 broken sequence", {24'd0, rb}, 32'h44);
        reg_read(6'h1D, rb); chk("R7 sync readback", {24'd0, rb}, 32'h02);
        reg_write(6'h14, 8'hFE);
        reg_write(6'h18, 8'h04);
        reg_write(6'h1D, 8'h03);
        reg_write(6'h0A, 8'h55);
        reg_write(6'h1D, 8'h02);
        m_scratch = 8'h00; m_ifmt = 8'h00; m_conv = 8'h00; m_sync = 8'h00;
        reg_read(6'h0A, rb); chk("R7 scratch default", {24'd0, rb}, 32'h00);
        reg_read(6'h14, rb); chk("R7 ifmt default", {24'd0, rb}, 32'h00);
        reg_read(6'h18, rb); chk("R7 conv default", {24'd0, rb}, 32'h00);
        reg_read(6'h1D, rb); chk("R7 sync default", {24'd0, rb}, 32'h00);
        push(24'h5A5A5A, 1'b1, "R7 mode back to continuous");

        // R5: streaming
        reg_write(6'h14, 8'h01); m_ifmt = 8'h01;
        push(24'hC0FFEE, 1'b1, "R8 continuous");
        stream_read(8'h00, rd);
        chk("R5 stream frame", {8'd0, rd}, 32'h00C0FFEE);
        push(24'h7E5D3B, 1'b1, "R8 continuous");
        stream_read(8'h0A, rd);
        chk("R5 stream ignores command", {8'd0, rd}, 32'h007E5D3B);
        stream_read(8'h99, rd);
        chk("R5 stream repeat", {8'd0, rd}, 32'h007E5D3B);

        // R6: exit streaming with a result-register read command
        stream_read(8'h6C, rd);
        chk("R6 exit frame data", {8'd0, rd}, 32'h007E5D3B);
        m_ifmt = 8'h00;
        reg_read(6'h14, rb); chk("R6 ifmt cleared", {24'd0, rb}, 32'h00);
        reg_read(6'h0A, rb); chk("R5 no write in stream", {24'd0, rb}, 32'h00);
        data_read(rd);
        chk("R6 normal read after exit", {8'd0, rd}, 32'h007E5D3B);

        // R11: MISO held while SCLK high across all frames
        chk("R11 miso stable high phase", r11_bad, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule